// File: doc/BRIEF.md
# DMA Channel Interrupt Status Controller

This register block gathers completion events from a set of audio DMA channels (ten by default) and turns them into one interrupt request. Each channel's done pulse sets a sticky status bit. The bit stays set until software writes a one to it. A per-channel enable register decides which status bits reach the interrupt line. The line itself is registered.

A small register bus gives access to the block. It has a byte address, a write strobe, write data and combinational read data. Through it software reads status and enable, clears status bits and writes the configuration word. Setting the clear control in the configuration word sends a one-cycle abort strobe to every channel that reports itself busy. Each of those channels then has its status bit set as though its transfer had finished normally.

The DMA engines, address generation and data movement are outside this block. It only observes done and busy per channel and drives abort per channel.

Top module: `dmairq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `irq` and `ch_abort` are 0, and the status, enable and configuration words all read as zero.
- R2: Status is at byte offset 0x00, enable at 0x04 and configuration at 0x08. Channel n occupies bit 2n of the status and enable words. All odd bits, all bits at or above position 2*NUM_CH, and the whole configuration word read as zero.
- R3: A `ch_done` pulse on channel n sets status bit 2n on the next clock edge, whatever the enable bit of that channel holds.
- R4: A write to offset 0x00 clears every status bit written as 1. Bits written as 0 keep their value.
- R5: If a done event and a write-1-to-clear reach the same channel in the same cycle, the status bit ends up set.
- R6: A set status bit stays set, across further done events and across any number of cycles, until a write-1-to-clear reaches it.
- R7: `irq` is a register that holds the OR over all channels of (status AND enable). It follows a change of status or enable one cycle later.
- R8: A write to offset 0x04 loads enable bit n from write-data bit 2n. The other write-data bits are dropped, and enable changes never alter status.
- R9: A write to offset 0x08 with bit 8 set drives `ch_abort` high for exactly one cycle, in the cycle after the write edge. Only channels whose `ch_busy` was high at the write edge are aborted. A write with bit 8 clear produces no strobe.
- R10: Every channel strobed by `ch_abort` has its status bit set on the clock edge that ends the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational from `bus_addr` |
| ch_done | input | NUM_CH (10) | Per-channel transfer-complete pulse |
| ch_busy | input | NUM_CH (10) | Per-channel transfer-running flag |
| ch_abort | output | NUM_CH (10) | Per-channel one-cycle abort strobe |
| irq | output | 1 | Combined, registered interrupt request |

## Verification
The bench builds the block at its default size: ten channels, a 32-bit data word and a 4-bit address. At that size the top status bit lands at position 18 and bit 19 is the first unused one, so the even-bit packing and the zero upper field are both checked at their true boundary. Random done pulses, busy patterns and bus writes run against a cycle-accurate model of status, enable, abort and interrupt. This exercises collisions between done events, write-1-to-clear and abort-driven completion that directed cases alone would rarely reach.

// File: rtl/dmairq_pkg.sv
// Package: shared register offsets and field positions of the DMA
// interrupt status controller. Assumes byte addressing of 32-bit words.
package dmairq_pkg;
    localparam int OFF_STATUS = 'h00;
    localparam int OFF_ENABLE = 'h04;
    localparam int OFF_CONFIG = 'h08;
    localparam int CFG_CLEAR_BIT = 8;
endpackage

// File: rtl/dmairq_regif.sv
// Module: register bus decode. Turns bus writes into a write-1-to-clear
// mask, an enable load and a clear trigger, and multiplexes read data.
// Assumes channel n maps to bit 2n; 2*NUM_CH must not exceed DATA_W.
module dmairq_regif #(
    parameter int NUM_CH = 10,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [NUM_CH-1:0] status_q,
    input  logic [NUM_CH-1:0] enable_q,
    output logic [NUM_CH-1:0] w1c_mask,
    output logic              en_load,
    output logic [NUM_CH-1:0] en_wdata,
    output logic              clear_go,
    output logic [DATA_W-1:0] bus_rdata
);
    import dmairq_pkg::*;

    logic sel_status, sel_enable, sel_config;
    logic [DATA_W-1:0] status_word, enable_word;
    logic wdata_unused;

    assign sel_status = (bus_addr == ADDR_W'(OFF_STATUS));
    assign sel_enable = (bus_addr == ADDR_W'(OFF_ENABLE));
    assign sel_config = (bus_addr == ADDR_W'(OFF_CONFIG));

    assign wdata_unused = ^bus_wdata;

    // Gather the even-bit write fields per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_fields
        assign w1c_mask[c] = bus_we & sel_status & bus_wdata[2*c];
        assign en_wdata[c] = bus_wdata[2*c];
    end

    assign en_load  = bus_we & sel_enable;
    assign clear_go = bus_we & sel_config & bus_wdata[CFG_CLEAR_BIT];

    // Spread channel bits onto the even positions of the read words.
    always_comb begin
        status_word = '0;
        enable_word = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            status_word[2*c] = status_q[c];
            enable_word[2*c] = enable_q[c];
        end
    end

    // Read multiplexer; configuration and unmapped offsets read zero.
    always_comb begin
        if (sel_status)      bus_rdata = status_word;
        else if (sel_enable) bus_rdata = enable_word;
        else                 bus_rdata = '0;
    end
endmodule

// File: rtl/dmairq_status.sv
// Module: sticky per-channel completion status. A set request wins over a
// clear request in the same cycle. Assumes synchronous active-low reset.
module dmairq_status #(
    parameter int NUM_CH = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_mask,
    input  logic [NUM_CH-1:0] w1c_mask,
    output logic [NUM_CH-1:0] status_q
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_bit
        // Hold, clear on write-one, set on event (event has priority).
        always_ff @(posedge clk) begin
            if (!rst_n)           status_q[c] <= 1'b0;
            else if (set_mask[c]) status_q[c] <= 1'b1;
            else if (w1c_mask[c]) status_q[c] <= 1'b0;
        end
    end
endmodule

// File: rtl/dmairq_abort.sv
// Module: converts a clear trigger into a one-cycle abort strobe for the
// channels that are busy at the trigger edge. Assumes clear_go lasts one cycle.
module dmairq_abort #(
    parameter int NUM_CH = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_go,
    input  logic [NUM_CH-1:0] ch_busy,
    output logic [NUM_CH-1:0] ch_abort
);
    // Capture the busy set on a trigger, otherwise drop the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        ch_abort <= '0;
        else if (clear_go) ch_abort <= ch_busy;
        else               ch_abort <= '0;
    end
endmodule

// File: rtl/dmairq_ctrl.sv
// Module: top of the DMA channel interrupt status controller. Combines bus
// decode, sticky status, enable register, abort strobes and a registered
// interrupt. Assumes one bus write per cycle and synchronous active-low reset.
module dmairq_ctrl #(
    parameter int NUM_CH = 10,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] ch_done,
    input  logic [NUM_CH-1:0] ch_busy,
    output logic [NUM_CH-1:0] ch_abort,
    output logic              irq
);
    logic [NUM_CH-1:0] status_q, enable_q, w1c_mask, en_wdata, set_mask;
    logic              en_load, clear_go;

    dmairq_regif #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regif (
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .status_q (status_q),
        .enable_q (enable_q),
        .w1c_mask (w1c_mask),
        .en_load  (en_load),
        .en_wdata (en_wdata),
        .clear_go (clear_go),
        .bus_rdata(bus_rdata)
    );

    dmairq_abort #(.NUM_CH(NUM_CH)) u_abort (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_go(clear_go),
        .ch_busy (ch_busy),
        .ch_abort(ch_abort)
    );

    // Aborted channels complete exactly like a normal done pulse.
    assign set_mask = ch_done | ch_abort;

    dmairq_status #(.NUM_CH(NUM_CH)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_mask(set_mask),
        .w1c_mask(w1c_mask),
        .status_q(status_q)
    );

    // Enable register, loaded by a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n)       enable_q <= '0;
        else if (en_load) enable_q <= en_wdata;
    end

    // Registered interrupt: OR of enabled status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(status_q & enable_q);
    end
endmodule

// File: rtl/dmairq_ctrl_chk.sv
// Module: assertion checker for dmairq_ctrl, attached through bind below.
// Assumes synchronous active-low reset held for at least two cycles.
module dmairq_ctrl_chk #(
    parameter int NUM_CH = 10,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NUM_CH-1:0] ch_done,
    input logic [NUM_CH-1:0] ch_busy,
    input logic [NUM_CH-1:0] ch_abort,
    input logic              irq,
    input logic [NUM_CH-1:0] st_q,
    input logic [NUM_CH-1:0] en_q,
    input logic [NUM_CH-1:0] clr_mask,
    input logic              clr_go
);
    logic [DATA_W-1:0] legal_bits;

    // Positions that may ever read as one.
    always_comb begin
        legal_bits = '0;
        for (int c = 0; c < NUM_CH; c++) legal_bits[2*c] = 1'b1;
    end

    assert_rdata_layout_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~legal_bits) == '0);

    assert_done_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($past(ch_done) & ~st_q) == '0);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($past(st_q) & ~$past(clr_mask) & ~st_q) == '0);

    assert_irq_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq == |($past(st_q) & $past(en_q)));

    assert_abort_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ch_abort == ($past(clr_go) ? $past(ch_busy) : '0));

    assert_abort_completes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($past(ch_abort) & ~st_q) == '0);
endmodule

bind dmairq_ctrl dmairq_ctrl_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rdata(bus_rdata),
    .ch_done  (ch_done),
    .ch_busy  (ch_busy),
    .ch_abort (ch_abort),
    .irq      (irq),
    .st_q     (status_q),
    .en_q     (enable_q),
    .clr_mask (w1c_mask),
    .clr_go   (clear_go)
);

// File: tb/dmairq_ctrl_test.sv
// Bench: directed corner cases followed by seeded random traffic, all
// compared against a cycle model built from the requirements.
module dmairq_ctrl_test;
    localparam int NCH = 10;
    localparam int DW  = 32;
    localparam int AW  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [NCH-1:0] ch_done = '0, ch_busy = '0, ch_abort;
    logic          irq;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    logic [NCH-1:0] m_st = '0, m_en = '0, m_ab = '0;
    logic           m_irq = 1'b0;

    dmairq_ctrl #(.NUM_CH(NCH), .DATA_W(DW), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_done(ch_done),
        .ch_busy(ch_busy), .ch_abort(ch_abort), .irq(irq)
    );

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] spread(input logic [NCH-1:0] v);
        logic [DW-1:0] w = '0;
        for (int c = 0; c < NCH; c++) w[2*c] = v[c];
        return w;
    endfunction

    function automatic logic [NCH-1:0] pack(input logic [DW-1:0] w);
        logic [NCH-1:0] v;
        for (int c = 0; c < NCH; c++) v[c] = w[2*c];
        return v;
    endfunction

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
        if (a == 4'h0) return spread(m_st);
        if (a == 4'h4) return spread(m_en);
        return '0;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock cycle of stimulus, model update and output comparison.
    task automatic step(input logic [NCH-1:0] done, input logic [NCH-1:0] busy,
                        input logic we, input logic [AW-1:0] addr,
                        input logic [DW-1:0] wd);
        logic [NCH-1:0] clr, st_n, en_n, ab_n;
        logic irq_n;
        @(negedge clk);
        ch_done = done; ch_busy = busy; bus_we = we; bus_addr = addr; bus_wdata = wd;
        clr   = (we && addr == 4'h0) ? pack(wd) : '0;
        st_n  = (m_st & ~clr) | done | m_ab;
        irq_n = |(m_st & m_en);
        en_n  = (we && addr == 4'h4) ? pack(wd) : m_en;
        ab_n  = (we && addr == 4'h8 && wd[8]) ? busy : '0;
        @(posedge clk);
        #1;
        m_st = st_n; m_en = en_n; m_ab = ab_n; m_irq = irq_n;
        check(ch_abort == m_ab, "R9 abort", DW'(ch_abort), DW'(m_ab));
        check(irq == m_irq, "R7 irq", DW'(irq), DW'(m_irq));
        check(bus_rdata == exp_read(addr), "R2 rdata", bus_rdata, exp_read(addr));
    endtask

    task automatic idle(input logic [AW-1:0] addr);
        step('0, '0, 1'b0, addr, '0);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h1A2B);
        repeat (3) @(posedge clk);
        // R1: reset values seen at the ports.
        for (int a = 0; a < 12; a += 4) begin
            @(negedge clk); bus_addr = AW'(a); #1;
            check(bus_rdata == '0, "R1 reset read", bus_rdata, '0);
        end
        check(irq == 1'b0, "R1 reset irq", DW'(irq), '0);
        check(ch_abort == '0, "R1 reset abort", DW'(ch_abort), '0);
        @(negedge clk); rst_n = 1'b1;

        // R3: done with enable clear sets status, irq stays low.
        step(10'b00_0000_1000, '0, 1'b0, 4'h0, '0);
        idle(4'h0);
        check(bus_rdata == 32'h40, "R3 status bit6", bus_rdata, 32'h40);
        check(irq == 1'b0, "R3 irq masked", DW'(irq), '0);

        // R8: all-ones enable write keeps even bits below 20 only.
        step('0, '0, 1'b1, 4'h4, 32'hFFFF_FFFF);
        check(irq == 1'b0, "R7 irq one cycle late", DW'(irq), '0);
        idle(4'h4);
        check(bus_rdata == 32'h0005_5555, "R8 enable layout", bus_rdata, 32'h0005_5555);
        check(irq == 1'b1, "R7 irq asserted", DW'(irq), 1);

        // R4: writing zero keeps, writing one clears.
        step('0, '0, 1'b1, 4'h0, 32'hAAAA_AAAA);
        idle(4'h0);
        check(bus_rdata == 32'h40, "R4 zero write ignored", bus_rdata, 32'h40);
        step('0, '0, 1'b1, 4'h0, 32'h40);
        check(bus_rdata == 32'h0, "R4 cleared", bus_rdata, 0);
        idle(4'h0);
        check(irq == 1'b0, "R7 irq dropped", DW'(irq), 0);

        // R5: event and clear on channel 5 together; event wins.
        step(10'b00_0010_0000, '0, 1'b1, 4'h0, 32'h400);
        check(bus_rdata == 32'h400, "R5 event wins", bus_rdata, 32'h400);
        // R6: further done and idle cycles keep it set.
        step(10'b00_0010_0000, '0, 1'b0, 4'h0, '0);
        repeat (3) idle(4'h0);
        check(bus_rdata == 32'h400, "R6 sticky", bus_rdata, 32'h400);
        step('0, '0, 1'b1, 4'h0, 32'h400);

        // R9/R10: clear with channels 1 and 9 busy.
        step('0, 10'b10_0000_0010, 1'b1, 4'h8, 32'h100);
        check(ch_abort == 10'b10_0000_0010, "R9 strobe", DW'(ch_abort), 32'h202);
        idle(4'h0);
        check(ch_abort == '0, "R9 one cycle", DW'(ch_abort), 0);
        check(bus_rdata == 32'h4_0004, "R10 aborted complete", bus_rdata, 32'h4_0004);
        // R9: bit 8 clear gives no strobe; configuration reads zero.
        step('0, '1, 1'b1, 4'h8, 32'hFFFF_FEFF);
        check(ch_abort == '0, "R9 no strobe", DW'(ch_abort), 0);
        idle(4'h8);
        check(bus_rdata == '0, "R2 config reads zero", bus_rdata, 0);

        // Random traffic against the model.
        for (int i = 0; i < 2000; i++) begin
            logic [NCH-1:0] d, b;
            logic w;
            logic [AW-1:0] a;
            logic [DW-1:0] wd;
            d  = NCH'($urandom & $urandom & $urandom);
            b  = NCH'($urandom);
            w  = ($urandom % 4) == 0;
            a  = AW'(4 * ($urandom % 3));
            wd = $urandom;
            step(d, b, w, a, wd);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule